// File: doc/BRIEF.md
# Four-Line Instruction Cache Victim Selector

This block decides which line of a four-line instruction cache gets refilled when an instruction fetch from the shared hub misses. Each line holds eight instructions, so the cache holds 32 in total. Every line has a 5-bit age counter. A line's counter clears when the line is used, either read on a hit or loaded on a miss. On each miss, the counters of all the other lines step up by one, and they stop at 31. In cycles with no hub fetch, every counter keeps its value.

In the default replacement mode, the line to refill is the line with the greatest age. It is found by a two-level compare tree: lines 0 and 1 are compared, lines 2 and 3 are compared, and then the two winners are compared. When ages are equal, the lower line index wins. In task mode, a two-bit task number names the line to refill directly, so each of four tasks owns one line. The counters keep ageing by the same rules in both modes.

The tag store, the data RAM and the refill path are outside this block. They appear only as a hit/miss indication, the index of the line that hit, and the refill line output.

Top module: `icache_victim_sel`

## Requirements
- R1: After reset, all ages are zero. With `task_mode` low, `refill_line` reads 0 and `refill_req` reads 0.
- R2: A fetch that hits (`fetch_valid`=1, `fetch_hit`=1) clears the age of line `hit_line` and leaves every other age unchanged.
- R3: A fetch that misses clears the age of the line named on `refill_line` and adds one to the age of each of the other three lines.
- R4: Ages saturate at 31. A line already at 31 stays at 31 on a miss that is not its own.
- R5: A cycle with `fetch_valid`=0 leaves all four ages unchanged, whatever the other inputs are.
- R6: With `task_mode`=0, `refill_line` is the binary index (0 to 3) of the line with the greatest age. On equal ages the lower index is chosen, at both levels of the compare tree.
- R7: With `task_mode`=1, `refill_line` equals `task_id`. Ages are still updated by R2 to R5.
- R8: `refill_req` is 1 exactly in cycles where `fetch_valid`=1 and `fetch_hit`=0. The output is combinational in the same cycle, and the ages update at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A hub instruction fetch takes place this cycle |
| fetch_hit | input | 1 | The fetch found its line in the cache |
| hit_line | input | 2 | Index of the line that hit |
| task_mode | input | 1 | 0: replace the oldest line; 1: the task number picks the line |
| task_id | input | 2 | Number of the task issuing the fetch |
| refill_line | output | 2 | Index of the line to reload on a miss |
| refill_req | output | 1 | A miss this cycle; `refill_line` is to be reloaded |

## Verification
The only place an age error can show up is the choice of `refill_line` on the next default-mode miss after the error. A counter that failed to clear, to age, to saturate or to hold through an idle cycle changes which line is chosen, or changes how an equal-age case resolves, within one to a few misses.

Saturation is the case that hides longest. It shows only after more than 31 misses aimed at other lines, when lines that have stopped at 31 must compare as equal instead of wrapping around to zero. The bench therefore drives a long task-mode miss run and then switches back to default mode to read out the result. It also compares every cycle of a mixed run against its own model of the ages.

// File: rtl/icache_victim_pkg.sv
package icache_victim_pkg;
  localparam int unsigned NUM_LINES  = 4;
  localparam int unsigned LINE_IDX_W = $clog2(NUM_LINES);
  localparam int unsigned AGE_W      = 5;
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  typedef logic [AGE_W-1:0]      age_t;
  typedef logic [LINE_IDX_W-1:0] line_t;

  // increment that stops at the top value
  function automatic age_t age_step(input age_t a);
    return (a == AGE_MAX) ? a : age_t'(a + age_t'(1));
  endfunction

  // returns 1 when candidate b is strictly older than a (ties keep a)
  function automatic logic b_is_older(input age_t a, input age_t b);
    return (b > a);
  endfunction
endpackage

// File: rtl/line_age_ctr.sv
module line_age_ctr
  import icache_victim_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output age_t age
);
  age_t age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    age_q <= '0;
    else if (clr)  age_q <= '0;
    else if (bump) age_q <= age_step(age_q);
  end

  assign age = age_q;

  a_r3_clear_on_use: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (age == '0));
  a_r3_ages_on_other_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !clr && age != AGE_MAX) |=> (age == $past(age) + age_t'(1)));
  a_r4_stays_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !clr && age == AGE_MAX) |=> (age == AGE_MAX));
  a_r5_hold_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!bump && !clr) |=> $stable(age));
endmodule

// File: rtl/age_max_tree.sv
module age_max_tree
  import icache_victim_pkg::*;
(
  input  age_t  age0,
  input  age_t  age1,
  input  age_t  age2,
  input  age_t  age3,
  output line_t oldest
);
  // first level: two pairwise compares
  logic  lo_pick, hi_pick;
  age_t  lo_age, hi_age;
  line_t lo_idx, hi_idx;

  always_comb begin
    lo_pick = b_is_older(age0, age1);
    hi_pick = b_is_older(age2, age3);
    lo_age  = lo_pick ? age1 : age0;
    hi_age  = hi_pick ? age3 : age2;
    lo_idx  = lo_pick ? line_t'(1) : line_t'(0);
    hi_idx  = hi_pick ? line_t'(3) : line_t'(2);
  end

  // second level: compare the two winners, ties to the lower pair
  always_comb begin
    oldest = b_is_older(lo_age, hi_age) ? hi_idx : lo_idx;
  end
endmodule

// File: rtl/icache_victim_sel.sv
module icache_victim_sel
  import icache_victim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_valid,
  input  logic       fetch_hit,
  input  logic [1:0] hit_line,
  input  logic       task_mode,
  input  logic [1:0] task_id,
  output logic [1:0] refill_line,
  output logic       refill_req
);
  logic hit_ev, miss_ev;
  logic [NUM_LINES-1:0] clr_vec, bump_vec;
  age_t ages [NUM_LINES];
  line_t oldest, victim;

  assign hit_ev  = fetch_valid &  fetch_hit;
  assign miss_ev = fetch_valid & ~fetch_hit;

  age_max_tree u_tree (
    .age0(ages[0]), .age1(ages[1]), .age2(ages[2]), .age3(ages[3]),
    .oldest(oldest)
  );

  assign victim = task_mode ? task_id : oldest;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign clr_vec[g]  = (hit_ev  && hit_line == line_t'(g)) ||
                         (miss_ev && victim   == line_t'(g));
    assign bump_vec[g] = miss_ev && (victim != line_t'(g));
    line_age_ctr u_ctr (
      .clk(clk), .rst_n(rst_n),
      .clr(clr_vec[g]), .bump(bump_vec[g]),
      .age(ages[g])
    );
  end

  assign refill_line = victim;
  assign refill_req  = miss_ev;

  a_r2_hit_ages_nobody: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |-> ($countones(bump_vec) == 0 && $countones(clr_vec) == 1));
  a_r3_miss_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ev |-> ($countones(clr_vec) == 1 && $countones(bump_vec) == NUM_LINES-1));
  a_r5_quiet_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> ($countones(clr_vec) == 0 && $countones(bump_vec) == 0));
  a_r6_pick_is_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && !task_mode) |->
      (ages[refill_line] >= ages[0] && ages[refill_line] >= ages[1] &&
       ages[refill_line] >= ages[2] && ages[refill_line] >= ages[3]));
  a_r7_task_picks: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && task_mode) |-> (refill_line == task_id));
  a_r8_req_only_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |-> (fetch_valid && !fetch_hit));
endmodule

// File: tb/icache_victim_sel_tb.sv
module icache_victim_sel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic fetch_valid = 0, fetch_hit = 0, task_mode = 0;
  logic [1:0] hit_line = 0, task_id = 0;
  logic [1:0] refill_line;
  logic refill_req;

  int checks = 0, fails = 0;
  bit done = 0;
  int mdl [4];
  logic [2:0] exp_q [$];
  string tag_q [$];
  event sample_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_victim_sel dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_hit(fetch_hit),
    .hit_line(hit_line), .task_mode(task_mode), .task_id(task_id),
    .refill_line(refill_line), .refill_req(refill_req)
  );

  function automatic int model_oldest();
    int best = 0;
    for (int k = 1; k < 4; k++) if (mdl[k] > mdl[best]) best = k;
    return best;
  endfunction

  // monitor: pops expected items and compares mid-cycle
  initial begin
    forever begin
      @(sample_ev);
      #1;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({refill_req, refill_line} !== e) begin
          fails++;
          $display("FAIL %s: req/line actual %0b/%0d expected %0b/%0d",
                   t, refill_req, refill_line, e[2], e[1:0]);
        end
      end
    end
  end

  task automatic step(input logic v, input logic h, input logic [1:0] hl,
                      input logic tm, input logic [1:0] tid, input string tag);
    int vic;
    @(negedge clk);
    fetch_valid = v; fetch_hit = h; hit_line = hl; task_mode = tm; task_id = tid;
    vic = tm ? int'(tid) : model_oldest();
    exp_q.push_back({v & ~h, 2'(vic)});
    tag_q.push_back(tag);
    #1 -> sample_ev;
    @(posedge clk);
    if (v && h) mdl[hl] = 0;
    else if (v) begin
      for (int k = 0; k < 4; k++)
        if (k == vic) mdl[k] = 0;
        else if (mdl[k] < 31) mdl[k]++;
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) mdl[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    step(0, 0, 0, 0, 0, "R1");
    // R3/R6: rotating misses from all-zero ages
    for (int k = 0; k < 5; k++) step(1, 0, 0, 0, 0, "R3");
    // R2: hits reshape ages
    step(1, 1, 2'd1, 0, 0, "R2");
    step(1, 1, 2'd3, 0, 0, "R2");
    step(1, 0, 0, 0, 0, "R6");
    // R5: idle with noisy inputs
    for (int k = 0; k < 4; k++) step(0, k[0], 2'(k), 0, 2'(k), "R5");
    step(1, 0, 0, 0, 0, "R5");
    // R7/R4: task mode, one task misses many times
    for (int k = 0; k < 40; k++) step(1, 0, 0, 1, 2'd0, "R7");
    // R4/R6: lines 1..3 stuck at 31, tie goes to line 1
    step(1, 1, 2'd0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, "R6");
    step(1, 1, 2'd3, 1, 2'd2, "R8");
    // mixed run
    for (int i = 0; i < 300; i++) begin
      logic v, h, tm;
      v  = (i % 5) != 0;
      h  = (i % 3) == 0;
      tm = ((i / 37) % 2) == 1;
      step(v, h, 2'(i * 3), tm, 2'(i / 7), tm ? "R7" : "R6");
    end
    step(0, 0, 0, 0, 0, "R8");
    #(CLK_PERIOD*2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule